// File: doc/BRIEF.md
# Power Domain Sequencer with Interconnect Idle Handshake

This block controls four switchable power domains through a small register file. For every domain, software programs an off request and an interconnect idle request. The block drives two outputs per domain: a power-switch command and an idle request towards that domain's interconnect port. Two inputs return from each port: an idle acknowledge and an idle status. Both pass through a synchronizer before any logic uses them.

The switch command for a domain turns off only after two conditions hold: software has asked for the domain to be off, and the port has reported both acknowledge and idle. Clearing the off request turns the switch back on in the next cycle. The power status bit that software reads does not follow the switch command at once. It changes only after a programmable number of cycles. A power-down count and a power-up count exist for each of two groups: a core group covering domains 0 to 2, and a graphics group covering domain 3.

When software powers a domain down, it sets the idle request, waits for acknowledge and idle, sets the off bit, and then waits for the status. When it powers the domain up, it clears the off bit, waits for the status, and then clears the idle request.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset, the switch control register, the status register and the idle request register all read 0, and all four count registers read 24. The `sw_off` and `idle_req` outputs are 0.
- R2: Writes to offset 0x08 store the off request of domains 0, 1, 2 and 3 in bit positions 7, 14, 8 and 9. Writes to offset 0x10 store their idle requests in bits 4, 9, 3 and 2, and those bits appear on `idle_req[3:0]` in the cycle after the write. Unmapped bits read as 0.
- R3: Offset 0x14 is read-only. Each domain's synchronized idle status reads at its idle-request bit position, and its synchronized acknowledge reads 16 positions higher. Writes to 0x14 change nothing.
- R4: `sw_off[d]` rises only in a cycle after the off request for domain d is set and both the synchronized acknowledge and idle of domain d are 1. While either of them is missing, the switch stays on.
- R5: Clearing the off request of a domain drops `sw_off[d]` on the next clock edge, whatever the handshake inputs are doing.
- R6: The status register at 0x0C reports domains 0, 1, 2 and 3 at bits 7, 10, 8 and 9, where 1 means off. A bit takes the value of `sw_off[d]` exactly N clock edges after `sw_off[d]` changes. N is the power-down count when the switch turns off and the power-up count when it turns on. A count of 0 behaves like 1.
- R7: If `sw_off[d]` returns to the state that the status already shows before the count expires, the status never changes. The next transition counts again from zero.
- R8: Reads of any offset other than 0x08, 0x0C, 0x10, 0x14, 0x34, 0x38, 0x3C and 0x40 return 0. Writes to the status register change nothing.
- R9: The core down and up counts sit at 0x34 and 0x38, and the graphics down and up counts at 0x3C and 0x40. Each holds the low CNT_W bits written and reads them back. The core pair times domains 0 to 2; the graphics pair times domain 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| ic_ack | input | 4 | Idle acknowledge from each domain's interconnect port, asynchronous |
| ic_idle | input | 4 | Idle status from each domain's interconnect port, asynchronous |
| idle_req | output | 4 | Idle request to each domain's interconnect port |
| sw_off | output | 4 | Power-switch command per domain, 1 = off |

## Verification
The checker watches several rules on every clock cycle:
- the switch never turns off without a completed acknowledge-and-idle handshake;
- a cleared off request always releases the switch on the next edge;
- a status bit only ever moves towards the current switch command;
- idle requests change only after a write to their register;
- unmapped offsets read as zero.

Some properties need the bench's directed scenarios because they depend on counting cycles against programmed counts:
- the exact number of edges between a switch change and its status update, for each group;
- the count restarting when a transition is reversed;
- the bit placement of every register;
- the read-only behaviour of the acknowledge/idle word.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;

    localparam int NUM_DOM   = 4;
    localparam int ACK_SHIFT = 16;

    localparam int OFF_SW_CTRL = 'h08;
    localparam int OFF_STATUS  = 'h0C;
    localparam int OFF_IDLE_RQ = 'h10;
    localparam int OFF_HSHAKE  = 'h14;
    localparam int OFF_CORE_DN = 'h34;
    localparam int OFF_CORE_UP = 'h38;
    localparam int OFF_GFX_DN  = 'h3C;
    localparam int OFF_GFX_UP  = 'h40;

    // bit position of each domain's off request in the switch control word
    function automatic int sw_bit(input int d);
        case (d)
            0:       return 7;
            1:       return 14;
            2:       return 8;
            default: return 9;
        endcase
    endfunction

    // bit position of each domain's off flag in the status word
    function automatic int stat_bit(input int d);
        case (d)
            0:       return 7;
            1:       return 10;
            2:       return 8;
            default: return 9;
        endcase
    endfunction

    // bit position of each domain's idle request (and idle status)
    function automatic int rq_bit(input int d);
        case (d)
            0:       return 4;
            1:       return 9;
            2:       return 3;
            default: return 2;
        endcase
    endfunction

    // domain 3 is timed by the graphics count pair, the rest by the core pair
    function automatic bit uses_gfx_cnt(input int d);
        return d == 3;
    endfunction

endpackage

// File: rtl/pwr_dom_sync.sv
module pwr_dom_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_dom_timer.sv
module pwr_dom_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             target_off,
    input  logic [CNT_W-1:0] down_lim,
    input  logic [CNT_W-1:0] up_lim,
    output logic             off_status
);

    typedef struct packed {
        logic             off;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   cnt_inc;

    always_comb begin
        st_d    = st_q;
        lim     = target_off ? down_lim : up_lim;
        cnt_inc = {1'b0, st_q.cnt} + (CNT_W+1)'(1);
        if (target_off == st_q.off) begin
            st_d.cnt = '0;
        end else if (cnt_inc >= {1'b0, lim}) begin
            st_d.off = target_off;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_status = st_q.off;

endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
    import pwr_dom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_CNT   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [3:0]        ic_ack,
    input  logic [3:0]        ic_idle,
    output logic [3:0]        idle_req,
    output logic [3:0]        sw_off
);

    localparam int ND = NUM_DOM;
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RESET_CNT);

    typedef struct packed {
        logic [ND-1:0]    ctrl_off;
        logic [ND-1:0]    req;
        logic [ND-1:0]    sw_off;
        logic [CNT_W-1:0] core_dn;
        logic [CNT_W-1:0] core_up;
        logic [CNT_W-1:0] gfx_dn;
        logic [CNT_W-1:0] gfx_up;
    } regs_t;

    regs_t st_d, st_q;

    logic [2*ND-1:0] sync_in, sync_out;
    logic [ND-1:0]   ack_s, idle_s, stat_off, ctrl_off_w;
    logic            unused_wdata;

    logic hit_ctrl, hit_stat, hit_req, hit_hs;
    logic hit_cdn, hit_cup, hit_gdn, hit_gup;

    assign hit_ctrl = bus_addr == ADDR_W'(OFF_SW_CTRL);
    assign hit_stat = bus_addr == ADDR_W'(OFF_STATUS);
    assign hit_req  = bus_addr == ADDR_W'(OFF_IDLE_RQ);
    assign hit_hs   = bus_addr == ADDR_W'(OFF_HSHAKE);
    assign hit_cdn  = bus_addr == ADDR_W'(OFF_CORE_DN);
    assign hit_cup  = bus_addr == ADDR_W'(OFF_CORE_UP);
    assign hit_gdn  = bus_addr == ADDR_W'(OFF_GFX_DN);
    assign hit_gup  = bus_addr == ADDR_W'(OFF_GFX_UP);

    assign unused_wdata = ^bus_wdata;

    // handshake inputs cross into this clock before use
    assign sync_in = {ic_idle, ic_ack};

    pwr_dom_sync #(
        .WIDTH  (2*ND),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .sync_out (sync_out)
    );

    assign ack_s  = sync_out[ND-1:0];
    assign idle_s = sync_out[2*ND-1:ND];

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (hit_ctrl) begin
                for (int d = 0; d < ND; d++) st_d.ctrl_off[d] = bus_wdata[sw_bit(d)];
            end
            if (hit_req) begin
                for (int d = 0; d < ND; d++) st_d.req[d] = bus_wdata[rq_bit(d)];
            end
            if (hit_cdn) st_d.core_dn = bus_wdata[CNT_W-1:0];
            if (hit_cup) st_d.core_up = bus_wdata[CNT_W-1:0];
            if (hit_gdn) st_d.gfx_dn  = bus_wdata[CNT_W-1:0];
            if (hit_gup) st_d.gfx_up  = bus_wdata[CNT_W-1:0];
        end
        // switch: off only after a complete idle handshake, on at once
        for (int d = 0; d < ND; d++) begin
            if (!st_q.ctrl_off[d]) begin
                st_d.sw_off[d] = 1'b0;
            end else if (ack_s[d] && idle_s[d]) begin
                st_d.sw_off[d] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl_off: '0, req: '0, sw_off: '0,
                      core_dn: CNT_RST, core_up: CNT_RST,
                      gfx_dn: CNT_RST, gfx_up: CNT_RST};
        end else begin
            st_q <= st_d;
        end
    end

    // per-domain status timers; the count group is picked per domain
    for (genvar g = 0; g < ND; g++) begin : g_dom
        logic [CNT_W-1:0] dn_lim, up_lim;
        if (uses_gfx_cnt(g)) begin : g_gfx
            assign dn_lim = st_q.gfx_dn;
            assign up_lim = st_q.gfx_up;
        end else begin : g_core
            assign dn_lim = st_q.core_dn;
            assign up_lim = st_q.core_up;
        end

        pwr_dom_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .target_off (st_q.sw_off[g]),
            .down_lim   (dn_lim),
            .up_lim     (up_lim),
            .off_status (stat_off[g])
        );
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            for (int d = 0; d < ND; d++) bus_rdata[sw_bit(d)] = st_q.ctrl_off[d];
        end
        if (hit_stat) begin
            for (int d = 0; d < ND; d++) bus_rdata[stat_bit(d)] = stat_off[d];
        end
        if (hit_req) begin
            for (int d = 0; d < ND; d++) bus_rdata[rq_bit(d)] = st_q.req[d];
        end
        if (hit_hs) begin
            for (int d = 0; d < ND; d++) begin
                bus_rdata[rq_bit(d)]             = idle_s[d];
                bus_rdata[rq_bit(d) + ACK_SHIFT] = ack_s[d];
            end
        end
        if (hit_cdn) bus_rdata[CNT_W-1:0] = st_q.core_dn;
        if (hit_cup) bus_rdata[CNT_W-1:0] = st_q.core_up;
        if (hit_gdn) bus_rdata[CNT_W-1:0] = st_q.gfx_dn;
        if (hit_gup) bus_rdata[CNT_W-1:0] = st_q.gfx_up;
    end

    assign idle_req   = st_q.req;
    assign sw_off     = st_q.sw_off;
    assign ctrl_off_w = st_q.ctrl_off;

endmodule

// File: rtl/pwr_dom_ctrl_chk.sv
module pwr_dom_ctrl_chk
    import pwr_dom_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [3:0]        idle_req,
    input logic [3:0]        sw_off,
    input logic [3:0]        ctrl_off,
    input logic [3:0]        ack_s,
    input logic [3:0]        idle_s,
    input logic [3:0]        stat_off
);

    logic mapped;
    assign mapped = bus_addr == ADDR_W'(OFF_SW_CTRL) || bus_addr == ADDR_W'(OFF_STATUS)
                 || bus_addr == ADDR_W'(OFF_IDLE_RQ) || bus_addr == ADDR_W'(OFF_HSHAKE)
                 || bus_addr == ADDR_W'(OFF_CORE_DN) || bus_addr == ADDR_W'(OFF_CORE_UP)
                 || bus_addr == ADDR_W'(OFF_GFX_DN)  || bus_addr == ADDR_W'(OFF_GFX_UP);

    assert_idle_req_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(idle_req) |-> $past(bus_wr && bus_addr == ADDR_W'(OFF_IDLE_RQ)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);

    for (genvar i = 0; i < 4; i++) begin : g_chk
        assert_switch_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sw_off[i]) |-> $past(ctrl_off[i] && ack_s[i] && idle_s[i]));

        assert_switch_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_off[i] |=> !sw_off[i]);

        assert_status_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(stat_off[i]) |-> stat_off[i] == $past(sw_off[i]));
    end

endmodule

bind pwr_dom_ctrl pwr_dom_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .idle_req  (idle_req),
    .sw_off    (sw_off),
    .ctrl_off  (ctrl_off_w),
    .ack_s     (ack_s),
    .idle_s    (idle_s),
    .stat_off  (stat_off)
);

// File: tb/pwr_dom_ctrl_test.sv
module pwr_dom_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ic_ack, ic_idle, idle_req, sw_off;

    logic        hold = 1'b0;
    logic [3:0]  pipe1 = '0, pipe2 = '0, pipe3 = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // interconnect model: acknowledge trails the request, idle trails acknowledge
    always @(posedge clk) begin
        pipe1 <= idle_req;
        pipe2 <= pipe1;
        pipe3 <= pipe2;
    end
    assign ic_ack  = pipe2 & ~{4{hold}};
    assign ic_idle = pipe3 & ~{4{hold}};

    pwr_dom_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ic_ack    (ic_ack),
        .ic_idle   (ic_idle),
        .idle_req  (idle_req),
        .sw_off    (sw_off)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_rise(input int d);
        bit seen = 1'b0;
        for (int k = 0; k < 60 && !seen; k++) begin
            @(negedge clk);
            if (sw_off[d]) seen = 1'b1;
        end
        chk("R4 switch turned off after handshake", {31'b0, seen}, 32'd1);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl reset", 8'h08, 32'h0);
        rd_chk("R1 status reset", 8'h0C, 32'h0);
        rd_chk("R1 idle req reset", 8'h10, 32'h0);
        rd_chk("R1 core down reset", 8'h34, 32'd24);
        rd_chk("R1 core up reset", 8'h38, 32'd24);
        rd_chk("R1 gfx down reset", 8'h3C, 32'd24);
        rd_chk("R1 gfx up reset", 8'h40, 32'd24);
        chk("R1 outputs reset", {24'b0, sw_off, idle_req}, 32'h0);
    endtask

    task automatic t_handshake_gate();
        hold = 1'b1;
        wr(8'h10, 32'hFFFF_FFFF);
        chk("R2 idle_req drive", {28'b0, idle_req}, 32'hF);
        rd_chk("R2 idle req map", 8'h10, 32'h0000_021C);
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl map", 8'h08, 32'h0000_4380);
        repeat (10) @(negedge clk);
        chk("R4 no switch without ack", {28'b0, sw_off}, 32'h0);
        hold = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 switch after ack and idle", {28'b0, sw_off}, 32'hF);
        repeat (30) @(negedge clk);
        rd_chk("R6 all off status", 8'h0C, 32'h0000_0780);
        wr(8'h08, 32'h0);
        repeat (40) @(negedge clk);
        rd_chk("R6 all on status", 8'h0C, 32'h0);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_mirror();
        wr(8'h10, 32'h0000_0004);
        repeat (10) @(negedge clk);
        rd_chk("R3 ack and idle mirror", 8'h14, 32'h0004_0004);
        wr(8'h14, 32'h0);
        rd_chk("R3 write ignored", 8'h14, 32'h0004_0004);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);
        rd_chk("R3 mirror clears", 8'h14, 32'h0);
    endtask

    task automatic t_core_timing();
        wr(8'h34, 32'd5);
        wr(8'h38, 32'd3);
        rd_chk("R9 core down readback", 8'h34, 32'd5);
        rd_chk("R9 core up readback", 8'h38, 32'd3);
        wr(8'h10, 32'h0000_0010);
        wr(8'h08, 32'h0000_0080);
        wait_rise(0);
        repeat (4) @(negedge clk);
        rd_chk("R6 status before down count", 8'h0C, 32'h0);
        @(negedge clk);
        rd_chk("R6 status at down count", 8'h0C, 32'h0000_0080);
        wr(8'h08, 32'h0);
        chk("R5 switch still off in write cycle", {31'b0, sw_off[0]}, 32'd1);
        @(negedge clk);
        chk("R5 switch released", {31'b0, sw_off[0]}, 32'd0);
        repeat (2) @(negedge clk);
        rd_chk("R6 status before up count", 8'h0C, 32'h0000_0080);
        @(negedge clk);
        rd_chk("R6 status at up count", 8'h0C, 32'h0);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_gfx_timing();
        wr(8'h3C, 32'd7);
        wr(8'h10, 32'h0000_0004);
        wr(8'h08, 32'h0000_0200);
        wait_rise(3);
        repeat (6) @(negedge clk);
        rd_chk("R9 gfx status before its count", 8'h0C, 32'h0);
        @(negedge clk);
        rd_chk("R9 gfx status at its count", 8'h0C, 32'h0000_0200);
        wr(8'h08, 32'h0);
        repeat (30) @(negedge clk);
        rd_chk("R6 gfx back on", 8'h0C, 32'h0);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reversal();
        wr(8'h10, 32'h0000_0200);
        wr(8'h08, 32'h0000_4000);
        wait_rise(1);
        wr(8'h08, 32'h0);
        repeat (10) @(negedge clk);
        rd_chk("R7 reversed transition leaves status", 8'h0C, 32'h0);
        wr(8'h08, 32'h0000_4000);
        wait_rise(1);
        repeat (4) @(negedge clk);
        rd_chk("R7 count restarted from zero", 8'h0C, 32'h0);
        @(negedge clk);
        rd_chk("R7 status after full count", 8'h0C, 32'h0000_0400);
        wr(8'h08, 32'h0);
        repeat (10) @(negedge clk);
        wr(8'h10, 32'h0);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_unmapped();
        rd_chk("R8 offset 0x00", 8'h00, 32'h0);
        rd_chk("R8 offset 0x04", 8'h04, 32'h0);
        rd_chk("R8 offset 0x18", 8'h18, 32'h0);
        rd_chk("R8 offset 0x44", 8'h44, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd_chk("R8 status write ignored", 8'h0C, 32'h0);
        wr(8'h40, 32'h0001_2345);
        rd_chk("R9 count width truncation", 8'h40, 32'h0000_2345);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake_gate();
        t_mirror();
        t_core_timing();
        t_gfx_timing();
        t_reversal();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule